// File: doc/BRIEF.md
# Interrupt Source Controller

This block owns a bank of interrupt sources addressed by global numbers that start at a base value. Each source holds a target server, a live priority, a saved priority and four status flags: asserted, sent, rejected and masked-pending. Whether a source is level-driven or message-driven is fixed per source by a parameter mask. Devices report line changes or message events on one event port. The presentation side sends back rejects and end-of-interrupt notices, and it can ask for a resend sweep. Software-side configuration arrives as commands that set routing, query it, switch a source off or switch it back on.

Sources that become deliverable are marked with an internal pending bit. A single offer port carries (server, number, priority) with a valid/ready handshake. When several sources are pending, the lowest-numbered one is shown first. A priority of 0xFF masks a source. Switching a source off keeps its old priority so that switching it on can restore it. Within one cycle, notifications act in a fixed order: reject, then end-of-interrupt, then device event, then command, then resend.

Top module: `irq_source_ctrl`

## Requirements
- R1: After reset no offer is valid, every source reads back server 0 and priority 0xFF, and a query answers without error.
- R2: A message event (ev_level=1) on a source whose priority is not 0xFF produces an offer carrying that source's number, server and priority from the next cycle on.
- R3: A message event on a masked source makes no offer and sets masked-pending. A later command that leaves the source unmasked clears masked-pending and offers it.
- R4: A level source's asserted flag follows ev_level. The source is offered, and marked sent, only while it is unmasked, asserted and not already sent, so repeating a high level does not offer it again.
- R5: A reject marks the source rejected and clears its sent flag. On resend, a rejected message source drops the mark and is offered again if it is unmasked, and a level source reapplies the R4 rule.
- R6: An end-of-interrupt clears the sent flag of a level source, and it does not offer the source by itself. It leaves a message source unchanged.
- R7: Route (cmd_op=0) stores the server, and stores cmd_prio as both the priority and the saved priority. Query (cmd_op=1) returns the stored server and priority.
- R8: Off (cmd_op=2) sets the priority to 0xFF and copies the old priority into the saved priority. On (cmd_op=3) copies the saved priority into the priority. Two off commands in a row therefore leave 0xFF saved.
- R9: A command whose number lies outside [base, base+count), or a route whose server is at or above the server count, answers rsp_err=1 with zero fields and changes nothing. Events, rejects and end-of-interrupt notices with out-of-range numbers are ignored.
- R10: Offers leave one at a time through ofr_valid/ofr_ready. An offer stays valid until it is accepted, and the lowest-numbered pending source is always presented first.
- R11: If a command masks a source that has an offer waiting, the offer is withdrawn. A message source then gets masked-pending, and a level source gets its sent flag cleared, so unmasking offers it again.
- R12: Notifications in the same cycle act in the order reject, end-of-interrupt, event, command, resend. A reject and a resend together therefore re-offer a message source at once.
- R13: Each command is answered exactly one cycle later on rsp_valid. The answer carries the source's server and priority as they are after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Device event strobe |
| ev_num | input | NUM_W | Global number of the event's source |
| ev_level | input | 1 | Line level (level source) or event present (message source) |
| rej_valid | input | 1 | Reject notice strobe |
| rej_num | input | NUM_W | Rejected source number |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_num | input | NUM_W | Source number being completed |
| resend | input | 1 | Sweep all sources for redelivery |
| cmd_valid | input | 1 | Configuration command strobe |
| cmd_op | input | 2 | 0 route, 1 query, 2 off, 3 on |
| cmd_num | input | NUM_W | Source number the command targets |
| cmd_server | input | SRV_W | Server for route |
| cmd_prio | input | 8 | Priority for route |
| rsp_valid | output | 1 | Command answer strobe |
| rsp_err | output | 1 | Command refused |
| rsp_server | output | SRV_W | Server after the command |
| rsp_prio | output | 8 | Priority after the command |
| ofr_valid | output | 1 | Offer available |
| ofr_ready | input | 1 | Presentation side takes the offer |
| ofr_server | output | SRV_W | Target server of the offer |
| ofr_num | output | NUM_W | Global source number offered |
| ofr_prio | output | 8 | Priority offered |

## Verification
The most delicate coincidence is a reject and a resend for the same message source in one cycle. The fixed ordering must set the rejected mark and then consume it, so the source is offered again at once rather than left stranded. This is provoked with a directed cycle that raises both strobes together, and random traffic repeats it alongside events and commands. Each cycle the outputs are compared with a bench model that applies the notifications in the stated order, so an offer missing one cycle after the coincidence, or a rejected flag left set, shows up as a mismatch on the offer port.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int PRIO_W = 8;
  typedef logic [PRIO_W-1:0] prio_t;
  localparam prio_t PRIO_MASKED = '1;

  // asrt is bit 0, sent bit 1, rej bit 2, mpend bit 3
  typedef struct packed {
    logic mpend;
    logic rej;
    logic sent;
    logic asrt;
  } src_flags_t;

  typedef enum logic [1:0] {
    OP_ROUTE = 2'd0,
    OP_QUERY = 2'd1,
    OP_OFF   = 2'd2,
    OP_ON    = 2'd3
  } cfg_op_e;

  function automatic logic num_in_window(int unsigned num, int unsigned base,
                                         int unsigned cnt);
    return (num >= base) && (num < base + cnt);
  endfunction

  function automatic logic level_deliverable(prio_t p, src_flags_t f);
    return f.asrt && !f.sent && (p != PRIO_MASKED);
  endfunction
endpackage

// File: rtl/isc_src_slot.sv
module isc_src_slot
  import isc_pkg::*;
#(
  parameter int SRV_W    = 4,
  parameter bit IS_LEVEL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_hit,
  input  logic             ev_val,
  input  logic             rej_hit,
  input  logic             eoi_hit,
  input  logic             cfg_hit,
  input  logic [SRV_W-1:0] cfg_srv,
  input  prio_t            cfg_prio,
  input  prio_t            cfg_saved,
  input  logic             resend,
  input  logic             grant,
  output logic [SRV_W-1:0] srv_q,
  output prio_t            prio_q,
  output prio_t            saved_q,
  output logic             pend_q
);
  src_flags_t       flags_q, flags_d;
  logic [SRV_W-1:0] srv_d;
  prio_t            prio_d, saved_d;
  logic             pend_d;

  always_comb begin
    flags_d = flags_q;
    pend_d  = pend_q;
    srv_d   = srv_q;
    prio_d  = prio_q;
    saved_d = saved_q;
    if (grant) pend_d = 1'b0;
    // 1: reject
    if (rej_hit) begin
      flags_d.rej  = 1'b1;
      flags_d.sent = 1'b0;
    end
    // 2: end of interrupt
    if (eoi_hit && IS_LEVEL) flags_d.sent = 1'b0;
    // 3: device event
    if (ev_hit) begin
      if (IS_LEVEL) begin
        flags_d.asrt = ev_val;
        if (level_deliverable(prio_d, flags_d)) begin
          flags_d.sent = 1'b1;
          pend_d       = 1'b1;
        end
      end else if (ev_val) begin
        if (prio_d == PRIO_MASKED) flags_d.mpend = 1'b1;
        else                       pend_d        = 1'b1;
      end
    end
    // 4: configuration write
    if (cfg_hit) begin
      srv_d   = cfg_srv;
      prio_d  = cfg_prio;
      saved_d = cfg_saved;
      if (prio_d == PRIO_MASKED && pend_d) begin
        pend_d = 1'b0;
        if (IS_LEVEL) flags_d.sent  = 1'b0;
        else          flags_d.mpend = 1'b1;
      end
      if (IS_LEVEL) begin
        if (level_deliverable(prio_d, flags_d)) begin
          flags_d.sent = 1'b1;
          pend_d       = 1'b1;
        end
      end else if (flags_d.mpend && prio_d != PRIO_MASKED) begin
        flags_d.mpend = 1'b0;
        pend_d        = 1'b1;
      end
    end
    // 5: resend sweep
    if (resend) begin
      if (IS_LEVEL) begin
        if (level_deliverable(prio_d, flags_d)) begin
          flags_d.sent = 1'b1;
          pend_d       = 1'b1;
        end
      end else if (flags_d.rej) begin
        flags_d.rej = 1'b0;
        if (prio_d != PRIO_MASKED) pend_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      pend_q  <= 1'b0;
      srv_q   <= '0;
      prio_q  <= PRIO_MASKED;
      saved_q <= PRIO_MASKED;
    end else begin
      flags_q <= flags_d;
      pend_q  <= pend_d;
      srv_q   <= srv_d;
      prio_q  <= prio_d;
      saved_q <= saved_d;
    end
  end

  // masked-pending is only ever held by a masked source
  assert_mpend_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q.mpend |-> (prio_q == PRIO_MASKED));

  // a reject not consumed by a same-cycle resend leaves the mark set
  assert_reject_marks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rej_hit && !resend) |=> flags_q.rej);

  // a level event copies the line into the asserted flag
  assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_LEVEL && ev_hit) |=> (flags_q.asrt == $past(ev_val)));
endmodule

// File: rtl/isc_offer_arb.sv
module isc_offer_arb
  import isc_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int SRV_W   = 4,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] pend,
  input  logic               ready,
  input  logic [SRV_W-1:0]   srv_a  [NUM_SRC],
  input  prio_t              prio_a [NUM_SRC],
  output logic               valid,
  output logic [IDX_W-1:0]   idx,
  output logic [SRV_W-1:0]   srv,
  output prio_t              prio,
  output logic [NUM_SRC-1:0] grant
);
  always_comb begin
    idx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pend[i]) idx = IDX_W'(i);
    end
  end

  assign valid = |pend;
  assign srv   = srv_a[idx];
  assign prio  = prio_a[idx];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_grant
    assign grant[i] = valid && ready && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/isc_cmd_unit.sv
module isc_cmd_unit
  import isc_pkg::*;
#(
  parameter int          NUM_SRC = 16,
  parameter int          NUM_SRV = 6,
  parameter int          NUM_W   = 16,
  parameter int          SRV_W   = 4,
  parameter int unsigned BASE    = 32'h1000,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  input  logic [1:0]         cmd_op,
  input  logic [NUM_W-1:0]   cmd_num,
  input  logic [SRV_W-1:0]   cmd_server,
  input  prio_t              cmd_prio,
  input  logic [SRV_W-1:0]   cur_srv   [NUM_SRC],
  input  prio_t              cur_prio  [NUM_SRC],
  input  prio_t              cur_saved [NUM_SRC],
  output logic [NUM_SRC-1:0] cfg_hit,
  output logic [SRV_W-1:0]   cfg_srv,
  output prio_t              cfg_prio,
  output prio_t              cfg_saved,
  output logic               rsp_valid,
  output logic               rsp_err,
  output logic [SRV_W-1:0]   rsp_server,
  output prio_t              rsp_prio
);
  cfg_op_e          op;
  logic             num_ok, err, wr;
  logic [IDX_W-1:0] sel;

  always_comb begin
    op     = cfg_op_e'(cmd_op);
    num_ok = num_in_window(32'(cmd_num), BASE, NUM_SRC);
    sel    = num_ok ? IDX_W'(cmd_num - NUM_W'(BASE)) : '0;
    err    = !num_ok || (op == OP_ROUTE && 32'(cmd_server) >= NUM_SRV);
    cfg_srv   = cur_srv[sel];
    cfg_prio  = cur_prio[sel];
    cfg_saved = cur_saved[sel];
    unique case (op)
      OP_ROUTE: begin
        cfg_srv   = cmd_server;
        cfg_prio  = cmd_prio;
        cfg_saved = cmd_prio;
      end
      OP_OFF: begin
        cfg_prio  = PRIO_MASKED;
        cfg_saved = cur_prio[sel];
      end
      OP_ON:   cfg_prio = cur_saved[sel];
      default: ;
    endcase
    wr = cmd_valid && !err && (op != OP_QUERY);
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
    assign cfg_hit[i] = wr && (sel == IDX_W'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_err    <= 1'b0;
      rsp_server <= '0;
      rsp_prio   <= '0;
    end else begin
      rsp_valid  <= cmd_valid;
      rsp_err    <= cmd_valid && err;
      rsp_server <= (cmd_valid && !err) ? cfg_srv  : '0;
      rsp_prio   <= (cmd_valid && !err) ? cfg_prio : '0;
    end
  end

  assert_rsp_after_cmd_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> rsp_valid);
  assert_no_spurious_rsp_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid);
endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
  import isc_pkg::*;
#(
  parameter int                 NUM_SRC    = 16,
  parameter int                 NUM_SRV    = 6,
  parameter int                 NUM_W      = 16,
  parameter int                 SRV_W      = 4,
  parameter int unsigned        BASE       = 32'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 16'hF0F0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic [NUM_W-1:0] ev_num,
  input  logic             ev_level,
  input  logic             rej_valid,
  input  logic [NUM_W-1:0] rej_num,
  input  logic             eoi_valid,
  input  logic [NUM_W-1:0] eoi_num,
  input  logic             resend,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [NUM_W-1:0] cmd_num,
  input  logic [SRV_W-1:0] cmd_server,
  input  logic [7:0]       cmd_prio,
  output logic             rsp_valid,
  output logic             rsp_err,
  output logic [SRV_W-1:0] rsp_server,
  output logic [7:0]       rsp_prio,
  output logic             ofr_valid,
  input  logic             ofr_ready,
  output logic [SRV_W-1:0] ofr_server,
  output logic [NUM_W-1:0] ofr_num,
  output logic [7:0]       ofr_prio
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [SRV_W-1:0]   srv_a   [NUM_SRC];
  prio_t              prio_a  [NUM_SRC];
  prio_t              saved_a [NUM_SRC];
  logic [NUM_SRC-1:0] pend_v, grant_v, cfg_hit;
  logic [SRV_W-1:0]   cfg_srv;
  prio_t              cfg_prio, cfg_saved;
  logic [IDX_W-1:0]   ofr_idx;

  // decoded notification targets
  logic             ev_ok, rej_ok, eoi_ok;
  logic [IDX_W-1:0] ev_idx, rej_idx, eoi_idx;

  always_comb begin
    ev_ok   = ev_valid  && num_in_window(32'(ev_num),  BASE, NUM_SRC);
    rej_ok  = rej_valid && num_in_window(32'(rej_num), BASE, NUM_SRC);
    eoi_ok  = eoi_valid && num_in_window(32'(eoi_num), BASE, NUM_SRC);
    ev_idx  = IDX_W'(ev_num  - NUM_W'(BASE));
    rej_idx = IDX_W'(rej_num - NUM_W'(BASE));
    eoi_idx = IDX_W'(eoi_num - NUM_W'(BASE));
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_slot
    isc_src_slot #(.SRV_W(SRV_W), .IS_LEVEL(LEVEL_MASK[i])) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_hit   (ev_ok  && ev_idx  == IDX_W'(i)),
      .ev_val   (ev_level),
      .rej_hit  (rej_ok && rej_idx == IDX_W'(i)),
      .eoi_hit  (eoi_ok && eoi_idx == IDX_W'(i)),
      .cfg_hit  (cfg_hit[i]),
      .cfg_srv  (cfg_srv),
      .cfg_prio (cfg_prio),
      .cfg_saved(cfg_saved),
      .resend   (resend),
      .grant    (grant_v[i]),
      .srv_q    (srv_a[i]),
      .prio_q   (prio_a[i]),
      .saved_q  (saved_a[i]),
      .pend_q   (pend_v[i])
    );
  end

  isc_cmd_unit #(
    .NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .NUM_W(NUM_W),
    .SRV_W(SRV_W), .BASE(BASE)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_num   (cmd_num),
    .cmd_server(cmd_server),
    .cmd_prio  (cmd_prio),
    .cur_srv   (srv_a),
    .cur_prio  (prio_a),
    .cur_saved (saved_a),
    .cfg_hit   (cfg_hit),
    .cfg_srv   (cfg_srv),
    .cfg_prio  (cfg_prio),
    .cfg_saved (cfg_saved),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_server(rsp_server),
    .rsp_prio  (rsp_prio)
  );

  isc_offer_arb #(.NUM_SRC(NUM_SRC), .SRV_W(SRV_W)) u_arb (
    .pend  (pend_v),
    .ready (ofr_ready),
    .srv_a (srv_a),
    .prio_a(prio_a),
    .valid (ofr_valid),
    .idx   (ofr_idx),
    .srv   (ofr_server),
    .prio  (ofr_prio),
    .grant (grant_v)
  );

  assign ofr_num = NUM_W'(BASE) + NUM_W'(ofr_idx);

  // an offer never carries the mask value
  assert_offer_unmasked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ofr_valid |-> (ofr_prio != PRIO_MASKED));

  // a stalled offer stays up unless a command could mask it
  assert_offer_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ofr_valid && !ofr_ready && !cmd_valid) |=> ofr_valid);

  // while stalled, only a lower-numbered source can take the front
  assert_offer_ascending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ofr_valid && !ofr_ready && !cmd_valid) |=> (ofr_num <= $past(ofr_num)));
endmodule

// File: tb/irq_source_ctrl_bench.sv
module irq_source_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 16;
  localparam int NUM_SRV = 6;
  localparam int NUM_W   = 16;
  localparam int SRV_W   = 4;
  localparam int BASE    = 32'h1000;
  localparam logic [NUM_SRC-1:0] LEVEL_MASK = 16'hF0F0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid, ev_level, rej_valid, eoi_valid, resend, cmd_valid, ofr_ready;
  logic [NUM_W-1:0] ev_num, rej_num, eoi_num, cmd_num;
  logic [1:0] cmd_op;
  logic [SRV_W-1:0] cmd_server;
  logic [7:0] cmd_prio;
  logic rsp_valid, rsp_err, ofr_valid;
  logic [SRV_W-1:0] rsp_server, ofr_server;
  logic [7:0] rsp_prio, ofr_prio;
  logic [NUM_W-1:0] ofr_num;

  irq_source_ctrl #(.NUM_SRC(NUM_SRC), .NUM_SRV(NUM_SRV), .NUM_W(NUM_W),
    .SRV_W(SRV_W), .BASE(BASE), .LEVEL_MASK(LEVEL_MASK)) u_irq_source_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_num(ev_num),
    .ev_level(ev_level), .rej_valid(rej_valid), .rej_num(rej_num),
    .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
    .cmd_server(cmd_server), .cmd_prio(cmd_prio), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_server(rsp_server), .rsp_prio(rsp_prio),
    .ofr_valid(ofr_valid), .ofr_ready(ofr_ready), .ofr_server(ofr_server),
    .ofr_num(ofr_num), .ofr_prio(ofr_prio));

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state, kept from the requirements
  int m_srv [NUM_SRC], m_prio [NUM_SRC], m_sav [NUM_SRC];
  bit m_asrt [NUM_SRC], m_sent [NUM_SRC], m_rej [NUM_SRC], m_mp [NUM_SRC], m_pend [NUM_SRC];
  bit e_rsp_v, e_rsp_err;
  int e_rsp_srv, e_rsp_prio;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  function automatic int win(int num);
    return (num >= BASE && num < BASE + NUM_SRC) ? num - BASE : -1;
  endfunction
  function automatic bit is_lvl(int i);
    return LEVEL_MASK[i];
  endfunction
  function automatic bit lvl_ok(int i);
    return m_asrt[i] && !m_sent[i] && m_prio[i] != 255;
  endfunction
  function automatic int first_pend();
    for (int i = 0; i < NUM_SRC; i++) if (m_pend[i]) return i;
    return -1;
  endfunction

  task automatic expect_eq(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_valid = 0; ev_num = '0; ev_level = 0; rej_valid = 0; rej_num = '0;
    eoi_valid = 0; eoi_num = '0; resend = 0; cmd_valid = 0; cmd_op = '0;
    cmd_num = '0; cmd_server = '0; cmd_prio = '0; ofr_ready = 0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < NUM_SRC; i++) begin
      m_srv[i] = 0; m_prio[i] = 255; m_sav[i] = 255;
      m_asrt[i] = 0; m_sent[i] = 0; m_rej[i] = 0; m_mp[i] = 0; m_pend[i] = 0;
    end
    e_rsp_v = 0;
  endtask

  task automatic level_try(int i);
    if (lvl_ok(i)) begin m_sent[i] = 1; m_pend[i] = 1; end
  endtask

  // one clock of the reference, in the order R12 prescribes
  task automatic model_step();
    int g, i, ns, np, nsv;
    bit err;
    if (ofr_ready) begin g = first_pend(); if (g >= 0) m_pend[g] = 0; end
    if (rej_valid) begin
      i = win(int'(rej_num));
      if (i >= 0) begin m_rej[i] = 1; m_sent[i] = 0; end
    end
    if (eoi_valid) begin
      i = win(int'(eoi_num));
      if (i >= 0 && is_lvl(i)) m_sent[i] = 0;
    end
    if (ev_valid) begin
      i = win(int'(ev_num));
      if (i >= 0) begin
        if (is_lvl(i)) begin m_asrt[i] = ev_level; level_try(i); end
        else if (ev_level) begin
          if (m_prio[i] == 255) m_mp[i] = 1; else m_pend[i] = 1;
        end
      end
    end
    e_rsp_v = cmd_valid;
    if (cmd_valid) begin
      i = win(int'(cmd_num));
      err = (i < 0) || (cmd_op == 2'd0 && int'(cmd_server) >= NUM_SRV);
      e_rsp_err = err; e_rsp_srv = 0; e_rsp_prio = 0;
      if (!err) begin
        ns = m_srv[i]; np = m_prio[i]; nsv = m_sav[i];
        case (cmd_op)
          2'd0: begin ns = int'(cmd_server); np = int'(cmd_prio); nsv = np; end
          2'd2: begin nsv = m_prio[i]; np = 255; end
          2'd3: np = m_sav[i];
          default: ;
        endcase
        e_rsp_srv = ns; e_rsp_prio = np;
        if (cmd_op != 2'd1) begin
          m_srv[i] = ns; m_prio[i] = np; m_sav[i] = nsv;
          if (np == 255 && m_pend[i]) begin
            m_pend[i] = 0;
            if (is_lvl(i)) m_sent[i] = 0; else m_mp[i] = 1;
          end
          if (is_lvl(i)) level_try(i);
          else if (m_mp[i] && np != 255) begin m_mp[i] = 0; m_pend[i] = 1; end
        end
      end
    end
    if (resend) begin
      for (int k = 0; k < NUM_SRC; k++) begin
        if (is_lvl(k)) level_try(k);
        else if (m_rej[k]) begin
          m_rej[k] = 0;
          if (m_prio[k] != 255) m_pend[k] = 1;
        end
      end
    end
  endtask

  task automatic compare_all();
    int g;
    g = first_pend();
    expect_eq("R10 offer valid", int'(ofr_valid), int'(g >= 0));
    if (g >= 0 && ofr_valid) begin
      expect_eq("R10 offer number", int'(ofr_num), BASE + g);
      expect_eq("R2 offer server", int'(ofr_server), m_srv[g]);
      expect_eq("R2 offer priority", int'(ofr_prio), m_prio[g]);
    end
    expect_eq("R13 response valid", int'(rsp_valid), int'(e_rsp_v));
    if (e_rsp_v && rsp_valid) begin
      expect_eq("R13 response error", int'(rsp_err), int'(e_rsp_err));
      expect_eq("R13 response server", int'(rsp_server), e_rsp_srv);
      expect_eq("R13 response priority", int'(rsp_prio), e_rsp_prio);
    end
  endtask

  // called just after a falling edge with the inputs already driven
  task automatic cyc();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all();
    idle();
  endtask

  task automatic send_ev(int num, bit lvl);
    ev_valid = 1; ev_num = NUM_W'(num); ev_level = lvl; cyc();
  endtask
  task automatic send_cmd(int op, int num, int srv, int prio);
    cmd_valid = 1; cmd_op = 2'(op); cmd_num = NUM_W'(num);
    cmd_server = SRV_W'(srv); cmd_prio = 8'(prio); cyc();
  endtask
  task automatic take();
    ofr_ready = 1; cyc();
  endtask
  task automatic want_offer(string tag, int idx);
    expect_eq(tag, int'(ofr_valid), 1);
    expect_eq(tag, int'(ofr_num), BASE + idx);
  endtask
  task automatic want_none(string tag);
    expect_eq(tag, int'(ofr_valid), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle();
    model_reset();
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    want_none("R1 no offer after reset");
    expect_eq("R1 no response after reset", int'(rsp_valid), 0);
    send_cmd(1, BASE + 0, 0, 0);
    expect_eq("R1 reset priority", int'(rsp_prio), 255);
    expect_eq("R1 reset server", int'(rsp_server), 0);
    expect_eq("R1 reset no error", int'(rsp_err), 0);
    // R7: route then query
    send_cmd(0, BASE + 1, 2, 5);
    expect_eq("R13 answer one cycle later", int'(rsp_valid), 1);
    send_cmd(1, BASE + 1, 0, 0);
    expect_eq("R7 stored server", int'(rsp_server), 2);
    expect_eq("R7 stored priority", int'(rsp_prio), 5);
    // R2: message event unmasked
    send_ev(BASE + 1, 1);
    want_offer("R2 message offer", 1);
    expect_eq("R2 offer server", int'(ofr_server), 2);
    expect_eq("R2 offer priority", int'(ofr_prio), 5);
    take();
    want_none("R10 accepted offer gone");
    // R3: masked message event, then unmask
    send_ev(BASE + 2, 1);
    want_none("R3 masked event held");
    send_cmd(0, BASE + 2, 1, 3);
    want_offer("R3 unmask delivers", 2);
    expect_eq("R3 unmask priority", int'(ofr_prio), 3);
    take();
    // R4: level source
    send_cmd(0, BASE + 4, 0, 4);
    want_none("R4 unasserted level not offered");
    send_ev(BASE + 4, 1);
    want_offer("R4 level offered", 4);
    take();
    send_ev(BASE + 4, 1);
    want_none("R4 level already sent");
    // R6: end of interrupt on level
    eoi_valid = 1; eoi_num = NUM_W'(BASE + 4); cyc();
    want_none("R6 eoi alone does not offer");
    send_ev(BASE + 4, 1);
    want_offer("R6 level offered after eoi", 4);
    take();
    // R5: reject and resend, level then message
    rej_valid = 1; rej_num = NUM_W'(BASE + 4); cyc();
    want_none("R5 reject alone does not offer");
    resend = 1; cyc();
    want_offer("R5 level resent", 4);
    take();
    rej_valid = 1; rej_num = NUM_W'(BASE + 1); cyc();
    resend = 1; cyc();
    want_offer("R5 message resent", 1);
    take();
    // R12: reject and resend in one cycle
    rej_valid = 1; rej_num = NUM_W'(BASE + 1); resend = 1; cyc();
    want_offer("R12 reject plus resend re-offers", 1);
    take();
    // R8: off / on
    send_cmd(2, BASE + 1, 0, 0);
    expect_eq("R8 off masks", int'(rsp_prio), 255);
    send_cmd(3, BASE + 1, 0, 0);
    expect_eq("R8 on restores", int'(rsp_prio), 5);
    send_cmd(2, BASE + 1, 0, 0);
    send_cmd(2, BASE + 1, 0, 0);
    send_cmd(3, BASE + 1, 0, 0);
    expect_eq("R8 double off loses saved", int'(rsp_prio), 255);
    send_cmd(0, BASE + 1, 2, 5);
    // R9: range checks
    send_cmd(1, BASE + NUM_SRC, 0, 0);
    expect_eq("R9 number above range", int'(rsp_err), 1);
    send_cmd(1, BASE - 1, 0, 0);
    expect_eq("R9 number below range", int'(rsp_err), 1);
    send_cmd(0, BASE + 1, NUM_SRV, 9);
    expect_eq("R9 server out of range", int'(rsp_err), 1);
    send_cmd(1, BASE + 1, 0, 0);
    expect_eq("R9 refused route left priority", int'(rsp_prio), 5);
    send_ev(BASE + NUM_SRC, 1);
    want_none("R9 out of range event ignored");
    // R10: ordering and hold
    send_cmd(0, BASE + 3, 1, 7);
    send_cmd(0, BASE + 0, 3, 2);
    send_ev(BASE + 3, 1);
    want_offer("R10 single pending", 3);
    send_ev(BASE + 0, 1);
    want_offer("R10 lower number first", 0);
    cyc();
    want_offer("R10 held while not ready", 0);
    take();
    want_offer("R10 next in order", 3);
    take();
    want_none("R10 drained");
    // R11: masking withdraws a waiting offer
    send_cmd(0, BASE + 5, 0, 6);
    send_ev(BASE + 5, 1);
    want_offer("R11 level waiting", 5);
    send_cmd(2, BASE + 5, 0, 0);
    want_none("R11 level withdrawn");
    send_cmd(3, BASE + 5, 0, 0);
    want_offer("R11 level back on", 5);
    take();
    send_ev(BASE + 3, 1);
    send_cmd(2, BASE + 3, 0, 0);
    want_none("R11 message withdrawn");
    send_cmd(3, BASE + 3, 0, 0);
    want_offer("R11 message back on", 3);
    expect_eq("R11 restored priority", int'(ofr_prio), 7);
    take();
    // random traffic checked against the reference every cycle
    for (int n = 0; n < 3000; n++) begin
      ev_valid  = ($urandom % 3) == 0;
      ev_num    = NUM_W'(BASE - 1 + int'($urandom % (NUM_SRC + 3)));
      ev_level  = ($urandom % 3) != 0;
      rej_valid = ($urandom % 6) == 0;
      rej_num   = NUM_W'(BASE - 1 + int'($urandom % (NUM_SRC + 3)));
      eoi_valid = ($urandom % 6) == 0;
      eoi_num   = NUM_W'(BASE - 1 + int'($urandom % (NUM_SRC + 3)));
      resend    = ($urandom % 10) == 0;
      cmd_valid = ($urandom % 4) == 0;
      cmd_op    = 2'($urandom % 4);
      cmd_num   = NUM_W'(BASE - 1 + int'($urandom % (NUM_SRC + 3)));
      cmd_server = SRV_W'($urandom % 8);
      cmd_prio  = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom % 16);
      ofr_ready = ($urandom % 2) == 0;
      cyc();
    end
    finish_run();
  end
endmodule